// File: doc/BRIEF.md
# Bus Clock Prescaler Chain

This block derives every bus-side clock of a small chip from one system clock. It produces six strobes: the main-bus clock, two peripheral-bus clocks, a timer clock for each peripheral bus, and the reference clock for the tick timer. So that the design stays in one clock domain, each derived clock is a clock-enable strobe. A strobe is high for one system-clock cycle per period of the derived clock, and logic downstream uses it to qualify its flops.

The dividers form a cascade. The main-bus divider counts system-clock cycles. Each peripheral divider and the tick divider count main-bus strobes. Each timer strobe is taken from its peripheral counter, so every strobe is phase-aligned with the strobes above it. A new divide code is loaded only when the divider's current period ends, so a period already under way always completes at its old length.

Top module: `busclk_div_chain`

## Requirements
- R1: In the first cycle after reset is released, all six strobes are high, and every programmable divider runs at divide-by-1 until its first period boundary.
- R2: The main-bus strobe repeats every N system cycles. N is 1 for any code with bit 3 clear, and 2, 4, 8, 16, 64, 128, 256 or 512 for codes 4'b1000 through 4'b1111.
- R3: Each peripheral strobe repeats every P main-bus strobes. P is 1 for any code with bit 2 clear, and 2, 4, 8 or 16 for codes 3'b100 through 3'b111.
- R4: A peripheral strobe is high only in cycles where the main-bus strobe is also high.
- R5: When P is 1, a timer strobe equals its peripheral strobe. Otherwise the timer strobe repeats every P/2 main-bus strobes and is high in every cycle where its peripheral strobe is high.
- R6: The tick strobe repeats every 8 main-bus strobes, and it is high only in cycles where the main-bus strobe is high.
- R7: A change of a divide code takes effect at the end of the period in progress. That period keeps its old length and the next period uses the new length.
- R8: Bus 1 and bus 2 divide independently: the code of one bus has no effect on the period of the other bus or of its timer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset |
| hdiv_code | input | 4 | Main-bus divide code |
| p1div_code | input | 3 | Peripheral bus 1 divide code |
| p2div_code | input | 3 | Peripheral bus 2 divide code |
| hclk_en | output | 1 | Main-bus clock strobe |
| p1clk_en | output | 1 | Peripheral bus 1 clock strobe |
| p2clk_en | output | 1 | Peripheral bus 2 clock strobe |
| tmr1_en | output | 1 | Timer group clock strobe from bus 1 |
| tmr2_en | output | 1 | Timer group clock strobe from bus 2 |
| tick_en | output | 1 | Tick-timer reference strobe |

## Verification
A counter that holds a wrong value, or that wraps at the wrong limit, changes the spacing of its strobe. This shows up in the first full period after the fault. The bench therefore measures the distance between strobes, counted in system cycles or in main-bus strobes, rather than matching cycle by cycle. A divide register that loads a new code at the wrong moment shows up as a single truncated or stretched period right after a code change, so those transitions are timed from a known strobe. Broken alignment shows up as a peripheral or tick strobe in a cycle with no main-bus strobe, and a monitor checks for that in every cycle.

// File: rtl/busclk_pkg.sv
package busclk_pkg;

    localparam int HSH_W  = 4;  // main-bus shift, up to 9
    localparam int HCNT_W = 9;  // counts up to 511
    localparam int PSH_W  = 3;  // peripheral shift, up to 4
    localparam int PCNT_W = 4;  // counts up to 15
    localparam int TSH    = 3;  // tick divides by 8
    localparam int NBUS   = 2;

    function automatic logic [HSH_W-1:0] hcode_to_sh(input logic [3:0] c);
        if (!c[3])
            return '0;
        else if (c[2])
            return {1'b0, c[2:0]} + 4'd2;  // 64..512 (32 is skipped)
        else
            return {1'b0, c[2:0]} + 4'd1;  // 2..16
    endfunction

    function automatic logic [PSH_W-1:0] pcode_to_sh(input logic [2:0] c);
        if (!c[2])
            return '0;
        else
            return {1'b0, c[1:0]} + 3'd1;
    endfunction

endpackage

// File: rtl/clkdiv_stage.sv
module clkdiv_stage #(
    parameter int SH_W   = 4,
    parameter int CNT_W  = 9,
    parameter int RST_SH = 0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             step,
    input  logic [SH_W-1:0]  sh_req,
    output logic             strobe,
    output logic [CNT_W-1:0] cnt_q,
    output logic [SH_W-1:0]  sh_q
);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic [SH_W-1:0]  sh;
    } st_t;

    st_t              st_d, st_q;
    logic [CNT_W-1:0] lim;

    always_comb begin
        lim = '0;
        for (int i = 0; i < CNT_W; i++)
            if (i < int'(st_q.sh)) lim[i] = 1'b1;
    end

    always_comb begin
        st_d = st_q;
        if (step) begin
            if (st_q.cnt == lim) begin
                st_d.cnt = '0;
                st_d.sh  = sh_req;
            end else begin
                st_d.cnt = st_q.cnt + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.cnt <= '0;
            st_q.sh  <= SH_W'(RST_SH);
        end else begin
            st_q <= st_d;
        end
    end

    assign strobe = step && (st_q.cnt == '0);
    assign cnt_q  = st_q.cnt;
    assign sh_q   = st_q.sh;

    // R2/R3: a period never runs past its limit
    a_r2_cnt_in_range: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.cnt <= lim);

    // R7: the divide changes only at the start of a new period
    a_r7_switch_on_boundary: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(st_q.sh) |-> (st_q.cnt == '0));

endmodule

// File: rtl/tmr_tap.sv
module tmr_tap #(
    parameter int SH_W  = 3,
    parameter int CNT_W = 4
) (
    input  logic             step,
    input  logic [CNT_W-1:0] cnt,
    input  logic [SH_W-1:0]  sh,
    output logic             tmr_en
);

    logic [SH_W-1:0]  tap_sh;
    logic [CNT_W-1:0] tap_mask;

    always_comb begin
        tap_sh = (sh == '0) ? '0 : sh - 1'b1;
        tap_mask = '0;
        for (int i = 0; i < CNT_W; i++)
            if (i < int'(tap_sh)) tap_mask[i] = 1'b1;
        tmr_en = step && ((cnt & tap_mask) == '0);
    end

endmodule

// File: rtl/busclk_div_chain.sv
module busclk_div_chain
    import busclk_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic [3:0] hdiv_code,
    input  logic [2:0] p1div_code,
    input  logic [2:0] p2div_code,
    output logic       hclk_en,
    output logic       p1clk_en,
    output logic       p2clk_en,
    output logic       tmr1_en,
    output logic       tmr2_en,
    output logic       tick_en
);

    logic [HCNT_W-1:0] h_cnt;
    logic [HSH_W-1:0]  h_sh;
    logic [TSH-1:0]    t_cnt;
    logic [1:0]        t_sh;

    logic [NBUS-1:0][2:0]        pcode;
    logic [NBUS-1:0]             p_en;
    logic [NBUS-1:0]             t_en;

    assign pcode = {p2div_code, p1div_code};

    clkdiv_stage #(.SH_W(HSH_W), .CNT_W(HCNT_W), .RST_SH(0)) u_hdiv (
        .clk    (clk),
        .rst_n  (rst_n),
        .step   (1'b1),
        .sh_req (hcode_to_sh(hdiv_code)),
        .strobe (hclk_en),
        .cnt_q  (h_cnt),
        .sh_q   (h_sh)
    );

    clkdiv_stage #(.SH_W(2), .CNT_W(TSH), .RST_SH(TSH)) u_tick (
        .clk    (clk),
        .rst_n  (rst_n),
        .step   (hclk_en),
        .sh_req (2'(TSH)),
        .strobe (tick_en),
        .cnt_q  (t_cnt),
        .sh_q   (t_sh)
    );

    for (genvar g = 0; g < NBUS; g++) begin : g_bus
        logic [PCNT_W-1:0] p_cnt;
        logic [PSH_W-1:0]  p_sh;

        clkdiv_stage #(.SH_W(PSH_W), .CNT_W(PCNT_W), .RST_SH(0)) u_pdiv (
            .clk    (clk),
            .rst_n  (rst_n),
            .step   (hclk_en),
            .sh_req (pcode_to_sh(pcode[g])),
            .strobe (p_en[g]),
            .cnt_q  (p_cnt),
            .sh_q   (p_sh)
        );

        tmr_tap #(.SH_W(PSH_W), .CNT_W(PCNT_W)) u_tap (
            .step   (hclk_en),
            .cnt    (p_cnt),
            .sh     (p_sh),
            .tmr_en (t_en[g])
        );

        // R4: peripheral strobe only with main-bus strobe
        a_r4_p_in_h: assert property (@(posedge clk) disable iff (!rst_n)
            p_en[g] |-> hclk_en);

        // R5: timer strobe covers every peripheral strobe
        a_r5_tmr_covers_p: assert property (@(posedge clk) disable iff (!rst_n)
            p_en[g] |-> t_en[g]);
    end

    assign p1clk_en = p_en[0];
    assign p2clk_en = p_en[1];
    assign tmr1_en  = t_en[0];
    assign tmr2_en  = t_en[1];

    // R6: tick strobe only with main-bus strobe
    a_r6_tick_in_h: assert property (@(posedge clk) disable iff (!rst_n)
        tick_en |-> hclk_en);

    // R5: timer strobe only with main-bus strobe
    a_r5_tmr_in_h: assert property (@(posedge clk) disable iff (!rst_n)
        (tmr1_en || tmr2_en) |-> hclk_en);

endmodule

// File: tb/busclk_div_chain_tb_top.sv
module busclk_div_chain_tb_top;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [3:0] hdiv_code = '0;
    logic [2:0] p1div_code = '0;
    logic [2:0] p2div_code = '0;
    logic       hclk_en, p1clk_en, p2clk_en, tmr1_en, tmr2_en, tick_en;

    int n_chk = 0;
    int n_bad = 0;
    int align_bad = 0;
    bit done = 0;

    always #2 clk = ~clk;  // 250 MHz

    busclk_div_chain dut_i (
        .clk(clk), .rst_n(rst_n), .hdiv_code(hdiv_code),
        .p1div_code(p1div_code), .p2div_code(p2div_code),
        .hclk_en(hclk_en), .p1clk_en(p1clk_en), .p2clk_en(p2clk_en),
        .tmr1_en(tmr1_en), .tmr2_en(tmr2_en), .tick_en(tick_en)
    );

    function automatic bit sig(input int s);
        case (s)
            0: return hclk_en;
            1: return p1clk_en;
            2: return p2clk_en;
            3: return tmr1_en;
            4: return tmr2_en;
            default: return tick_en;
        endcase
    endfunction

    function automatic int h_exp(input logic [3:0] c);
        if (!c[3]) return 1;
        if (c[2]) return 2 << (int'(c[2:0]) + 1);
        return 2 << int'(c[2:0]);
    endfunction

    function automatic int p_exp(input logic [2:0] c);
        if (!c[2]) return 1;
        return 2 << int'(c[1:0]);
    endfunction

    task automatic check(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // system cycles from one strobe of s to the next
    task automatic gap_sys(input int s, output int g);
        while (!sig(s)) @(negedge clk);
        g = 0;
        do begin
            @(negedge clk);
            g++;
        end while (!sig(s));
    endtask

    // main-bus strobes from one strobe of s to the next
    task automatic gap_h(input int s, output int g);
        while (!sig(s)) @(negedge clk);
        g = 0;
        do begin
            @(negedge clk);
            if (hclk_en) g++;
        end while (!sig(s));
    endtask

    // R4, R6: alignment monitor
    always @(negedge clk) begin
        if (rst_n && !hclk_en && (p1clk_en || p2clk_en || tmr1_en || tmr2_en || tick_en))
            align_bad++;
    end

    task automatic t_reset;
        check("R1 hclk after reset", int'(hclk_en), 1);
        check("R1 p1 after reset", int'(p1clk_en), 1);
        check("R1 p2 after reset", int'(p2clk_en), 1);
        check("R1 tmr1 after reset", int'(tmr1_en), 1);
        check("R1 tmr2 after reset", int'(tmr2_en), 1);
        check("R1 tick after reset", int'(tick_en), 1);
        @(negedge clk);
        check("R1 hclk second cycle", int'(hclk_en), 1);
    endtask

    task automatic t_hdiv;
        int g;
        for (int c = 0; c < 16; c++) begin
            hdiv_code = 4'(c);
            gap_sys(0, g);
            gap_sys(0, g);
            gap_sys(0, g);
            check($sformatf("R2 hclk code %0d", c), g, h_exp(4'(c)));
        end
        hdiv_code = '0;
        gap_sys(0, g);
        gap_sys(0, g);
    endtask

    task automatic t_pdiv;
        int g;
        for (int c = 0; c < 8; c++) begin
            p1div_code = 3'(c);
            p2div_code = 3'(7 - c);
            gap_h(1, g); gap_h(1, g); gap_h(1, g);
            check($sformatf("R3 p1 code %0d", c), g, p_exp(3'(c)));
            gap_h(3, g); gap_h(3, g);
            check($sformatf("R5 tmr1 code %0d", c), g,
                  p_exp(3'(c)) == 1 ? 1 : p_exp(3'(c)) / 2);
            gap_h(2, g); gap_h(2, g);
            check($sformatf("R8 p2 code %0d", 7 - c), g, p_exp(3'(7 - c)));
            gap_h(4, g); gap_h(4, g);
            check($sformatf("R5 tmr2 code %0d", 7 - c), g,
                  p_exp(3'(7 - c)) == 1 ? 1 : p_exp(3'(7 - c)) / 2);
        end
    endtask

    task automatic t_equal_timer;
        int diff = 0;
        p1div_code = 3'b010;
        gap_h(1, diff); gap_h(1, diff);
        diff = 0;
        for (int i = 0; i < 40; i++) begin
            @(negedge clk);
            if (tmr1_en != p1clk_en) diff++;
        end
        check("R5 tmr1 equals p1 at divide-by-1", diff, 0);
    endtask

    task automatic t_slow_h;
        int g;
        hdiv_code = 4'b1001;  // /4
        p1div_code = 3'b110;  // /8
        gap_sys(0, g); gap_sys(0, g);
        gap_sys(1, g); gap_sys(1, g);
        check("R3 p1 /8 under hclk /4 in sys cycles", g, 32);
        gap_h(5, g); gap_h(5, g);
        check("R6 tick period in hclk strobes", g, 8);
        gap_sys(5, g);
        check("R6 tick period in sys cycles", g, 32);
        hdiv_code = '0;
        gap_sys(0, g); gap_sys(0, g);
        gap_h(5, g); gap_h(5, g);
        check("R6 tick at hclk /1", g, 8);
    endtask

    task automatic t_switch;
        int g;
        hdiv_code = 4'b1011;  // /16
        gap_sys(0, g); gap_sys(0, g);
        @(negedge clk);
        @(negedge clk);
        hdiv_code = 4'b1000;  // /2
        g = 2;
        do begin
            @(negedge clk);
            g++;
        end while (!hclk_en);
        check("R7 old hclk period completes", g, 16);
        gap_sys(0, g);
        check("R7 new hclk period applies", g, 2);
        hdiv_code = '0;
        p1div_code = 3'b111;  // /16
        gap_h(1, g); gap_h(1, g);
        for (int i = 0; i < 3; i++) begin
            @(negedge clk);
            while (!hclk_en) @(negedge clk);
        end
        p1div_code = 3'b100;  // /2
        g = 3;
        do begin
            @(negedge clk);
            if (hclk_en) g++;
        end while (!p1clk_en);
        check("R7 old p1 period completes", g, 16);
        gap_h(1, g);
        check("R7 new p1 period applies", g, 2);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_hdiv();
        t_pdiv();
        t_equal_timer();
        t_slow_h();
        t_switch();
        check("R4 R6 strobe alignment violations", align_bad, 0);
        if (!done) begin
            done = 1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        #(4 * 150000);
        if (!done) begin
            done = 1;
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

endmodule